// File: doc/BRIEF.md
# Weight-Stationary Integer Matrix Unit

This block is a compact matrix engine for neural-network inference. It holds a square N x N matrix of signed 8-bit weights in registers. It then multiplies a run of B input rows against that matrix. Each input row has N signed 8-bit elements and comes from an on-chip row buffer. One row enters per clock, and the N 32-bit column sums of each row land in an accumulator store. There they either replace the stored row or are added to a partial sum already held at that address.

Weights arrive from an external FIFO into a shadow set, one row per cycle. A swap request copies a complete shadow set into the active set, but only while no multiply is running. The next weight set can therefore load while the current rows stream. A command gives the row count B, the source row address, the accumulator base address and the overwrite/accumulate choice. A busy flag and a one-cycle done pulse frame each command.

Top module: `wsmu_top`

## Requirements
- R1: After reset, busy, done, wfifo_pop and wset_ready are low, cmd_ready is high, every accumulator row reads zero, and the active weights are all zero (a command issued before any swap produces zero sums).
- R2: A wload_req seen while no fill is in progress starts a fill of N rows. One row is popped per cycle while wfifo_empty is low. The k-th row popped becomes weight row k, with element j at bits [8j+7:8j]. wset_ready rises after the N-th pop.
- R3: wfifo_pop is never high while wfifo_empty is high. A fill stalls while the FIFO is empty and resumes where it stopped. A partly filled set never becomes active, even if a swap is requested.
- R4: A swap request stays pending until the shadow set is complete and the unit is not busy. The shadow set then becomes active and wset_ready drops. Active weights never change while busy. A command accepted in the same cycle as a swap uses the new weights.
- R5: A command is accepted only when cmd_valid is high, busy is low and cmd_rows is nonzero. cmd_ready equals not-busy. A command offered while busy, or with zero rows, has no effect on the accumulators or on busy.
- R6: For input row b (b = 0..B-1), read from source address (cmd_src+b) mod SRC_DEPTH with element k at bits [8k+7:8k], output element j is the signed sum over k of x[k]*W[k][j], kept as 32-bit two's complement. It is stored at accumulator address (cmd_dst+b) mod ACC_DEPTH, with element j at bits [32j+31:32j]. src_row must hold the addressed row in the cycle after src_rd.
- R7: With cmd_accum = 1 each result row is added, element by element modulo 2^32, to the stored row. With cmd_accum = 0 it replaces the stored row.
- R8: After acceptance, src_rd is high for exactly the first B cycles, busy is high for exactly B+2 cycles, and done is a one-cycle pulse in the first cycle with busy low.
- R9: Accumulator rows outside the B addressed rows keep their values.
- R10: A weight fill may run while a command is busy. A wload_req arriving during a fill is ignored, so exactly N rows are popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfifo_empty | input | 1 | Weight FIFO has no row |
| wfifo_row | input | N*8 | Weight row at FIFO head |
| wfifo_pop | output | 1 | Consume FIFO head this cycle |
| wload_req | input | 1 | Start filling the shadow weight set |
| wswap_req | input | 1 | Request shadow-to-active swap |
| wset_ready | output | 1 | Shadow set complete, not yet swapped |
| cmd_valid | input | 1 | Command offered |
| cmd_rows | input | ROWS_W | Row count B |
| cmd_src | input | log2(SRC_DEPTH) | First source row address |
| cmd_dst | input | log2(ACC_DEPTH) | First accumulator row address |
| cmd_accum | input | 1 | 1 = add to stored rows, 0 = overwrite |
| cmd_ready | output | 1 | Unit can accept a command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| src_rd | output | 1 | Source buffer read strobe |
| src_addr | output | log2(SRC_DEPTH) | Source buffer read address |
| src_row | input | N*8 | Source row, valid the cycle after src_rd |
| acc_rd_addr | input | log2(ACC_DEPTH) | Accumulator readout address |
| acc_rd_row | output | N*32 | Accumulator row at acc_rd_addr |

## Verification
Every cycle, the assertions check four things: the FIFO is never popped while empty, the active weights stay frozen while busy, busy only starts from a valid nonzero command, and done marks the falling edge of busy as a single pulse with source reads confined to busy. Only the bench scenarios can show the arithmetic itself. They compare each accumulator row against an integer reference product in both overwrite and accumulate modes, with address wrap. They also show which weight set a command used around a stalled fill or a swap made during computation, and that refused commands leave no trace.

// File: rtl/wsmu_pkg.sv
// Shared constants and types for the weight-stationary matrix unit.
// Assumes 8-bit signed operands and 32-bit column sums throughout.
package wsmu_pkg;
    localparam int DATA_W = 8;
    localparam int ACC_W  = 32;

    typedef enum logic {
        WL_IDLE,
        WL_FILL
    } wload_state_e;
endpackage

// File: rtl/wsmu_weight_bank.sv
// Weight storage: a shadow set filled row by row from an external FIFO,
// and an active set fed to the multiply array. Assumes the FIFO head is
// valid whenever wfifo_empty is low; a swap copies only a complete set.
module wsmu_weight_bank
    import wsmu_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_req,
    input  logic                     wfifo_empty,
    input  logic [N*DATA_W-1:0]      wfifo_row,
    output logic                     wfifo_pop,
    input  logic                     swap_req,
    input  logic                     swap_allow,
    output logic                     set_ready,
    output logic [N*N*DATA_W-1:0]    act_w
);
    localparam int RW  = N * DATA_W;
    localparam int RCW = (N > 1) ? $clog2(N) : 1;

    wload_state_e    st;
    logic [RCW-1:0]  row_idx;
    logic [RW-1:0]   shadow [N];
    logic [RW-1:0]   active [N];
    logic            full;
    logic            pend;
    logic            do_swap;

    assign wfifo_pop = (st == WL_FILL) && !wfifo_empty;
    assign do_swap   = pend && full && swap_allow;
    assign set_ready = full;

    // Fill sequencer: start on request, one row per non-empty cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= WL_IDLE;
            row_idx <= '0;
            full    <= 1'b0;
        end else if (st == WL_IDLE && load_req) begin
            st      <= WL_FILL;
            row_idx <= '0;
            full    <= 1'b0;
        end else if (wfifo_pop) begin
            shadow[row_idx] <= wfifo_row;
            if (row_idx == RCW'(N - 1)) begin
                st   <= WL_IDLE;
                full <= 1'b1;
            end else begin
                row_idx <= row_idx + 1'b1;
            end
        end else if (do_swap) begin
            full <= 1'b0;
        end
    end

    // Swap request is held until it can be honoured.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend && !do_swap) || swap_req;
    end

    // Active set: cleared at reset, replaced only by a complete shadow set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) active[i] <= '0;
        end else if (do_swap) begin
            for (int i = 0; i < N; i++) active[i] <= shadow[i];
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_flat
        assign act_w[k*RW +: RW] = active[k];
    end
endmodule

// File: rtl/wsmu_mac_pipe.sv
// One pipeline stage of N column dot products: for each column j it sums
// x[k]*W[k][j] over k with signed 8x8 products widened to 32 bits, and
// registers the sums with a valid bit and an opaque tag.
module wsmu_mac_pipe
    import wsmu_pkg::*;
#(
    parameter int N     = 8,
    parameter int TAG_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [TAG_W-1:0]         in_tag,
    input  logic [N*DATA_W-1:0]      in_row,
    input  logic [N*N*DATA_W-1:0]    weights,
    output logic                     out_valid,
    output logic [TAG_W-1:0]         out_tag,
    output logic [N*ACC_W-1:0]       out_sums
);
    localparam int PW = 2 * DATA_W;

    logic [N*ACC_W-1:0] sums_c;

    for (genvar j = 0; j < N; j++) begin : g_col
        logic signed [ACC_W-1:0] col;
        // Column j dot product of the input row with weight column j.
        always_comb begin
            logic signed [PW-1:0] a;
            logic signed [PW-1:0] b;
            logic signed [PW-1:0] p;
            col = '0;
            for (int k = 0; k < N; k++) begin
                a   = {{DATA_W{in_row[k*DATA_W+DATA_W-1]}}, in_row[k*DATA_W +: DATA_W]};
                b   = {{DATA_W{weights[(k*N+j)*DATA_W+DATA_W-1]}},
                       weights[(k*N+j)*DATA_W +: DATA_W]};
                p   = a * b;
                col = col + {{(ACC_W-PW){p[PW-1]}}, p};
            end
        end
        assign sums_c[j*ACC_W +: ACC_W] = col;
    end

    // Stage register for sums, valid and tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_sums  <= '0;
        end else begin
            out_valid <= in_valid;
            out_tag   <= in_tag;
            out_sums  <= sums_c;
        end
    end
endmodule

// File: rtl/wsmu_acc_store.sv
// Accumulator memory of DEPTH rows of N 32-bit sums. A write either
// replaces a row or adds to it element-wise (read-modify-write in one
// cycle). Assumes at most one write per cycle; readout is combinational.
module wsmu_acc_store
    import wsmu_pkg::*;
#(
    parameter int N     = 8,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic                     wr_accum,
    input  logic [N*ACC_W-1:0]       wr_sums,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [N*ACC_W-1:0]       rd_row
);
    logic [N*ACC_W-1:0] mem [DEPTH];
    logic [N*ACC_W-1:0] old_row;
    logic [N*ACC_W-1:0] new_row;

    assign old_row = mem[wr_addr];

    for (genvar j = 0; j < N; j++) begin : g_upd
        assign new_row[j*ACC_W +: ACC_W] = wr_accum
            ? old_row[j*ACC_W +: ACC_W] + wr_sums[j*ACC_W +: ACC_W]
            : wr_sums[j*ACC_W +: ACC_W];
    end

    // Row storage: zeroed at reset, updated on each valid result row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= new_row;
        end
    end

    assign rd_row = mem[rd_addr];
endmodule

// File: rtl/wsmu_top.sv
// Weight-stationary matrix unit top. Accepts one command at a time,
// issues B source reads on consecutive cycles, runs each returned row
// through the MAC stage and writes the sums into the accumulator store.
// Assumes the source buffer returns a row the cycle after src_rd and
// that SRC_DEPTH and ACC_DEPTH are powers of two (addresses wrap).
module wsmu_top
    import wsmu_pkg::*;
#(
    parameter int N         = 8,
    parameter int SRC_DEPTH = 64,
    parameter int ACC_DEPTH = 32,
    parameter int ROWS_W    = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wfifo_empty,
    input  logic [N*DATA_W-1:0]          wfifo_row,
    output logic                         wfifo_pop,
    input  logic                         wload_req,
    input  logic                         wswap_req,
    output logic                         wset_ready,
    input  logic                         cmd_valid,
    input  logic [ROWS_W-1:0]            cmd_rows,
    input  logic [$clog2(SRC_DEPTH)-1:0] cmd_src,
    input  logic [$clog2(ACC_DEPTH)-1:0] cmd_dst,
    input  logic                         cmd_accum,
    output logic                         cmd_ready,
    output logic                         busy,
    output logic                         done,
    output logic                         src_rd,
    output logic [$clog2(SRC_DEPTH)-1:0] src_addr,
    input  logic [N*DATA_W-1:0]          src_row,
    input  logic [$clog2(ACC_DEPTH)-1:0] acc_rd_addr,
    output logic [N*ACC_W-1:0]           acc_rd_row
);
    localparam int SAW   = $clog2(SRC_DEPTH);
    localparam int DAW   = $clog2(ACC_DEPTH);
    localparam int TAG_W = DAW + 2;
    localparam int SW    = N * ACC_W;

    logic [N*N*DATA_W-1:0] act_w;
    logic                  accept;
    logic                  issue;
    logic [ROWS_W-1:0]     left;
    logic [SAW-1:0]        src_ptr;
    logic [DAW-1:0]        dst_ptr;
    logic                  mode_q;
    logic                  v1;
    logic [TAG_W-1:0]      tag1;
    logic                  v2;
    logic [TAG_W-1:0]      tag2;
    logic [SW-1:0]         sums2;
    logic                  last2;

    assign accept    = cmd_valid && !busy && (cmd_rows != '0);
    assign issue     = (left != '0);
    assign src_rd    = issue;
    assign src_addr  = src_ptr;
    assign cmd_ready = !busy;
    assign last2     = v2 && tag2[TAG_W-1];

    // Issue counter: latch the command, then step one row per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left    <= '0;
            src_ptr <= '0;
            dst_ptr <= '0;
            mode_q  <= 1'b0;
        end else if (accept) begin
            left    <= cmd_rows;
            src_ptr <= cmd_src;
            dst_ptr <= cmd_dst;
            mode_q  <= cmd_accum;
        end else if (issue) begin
            left    <= left - 1'b1;
            src_ptr <= src_ptr + 1'b1;
            dst_ptr <= dst_ptr + 1'b1;
        end
    end

    // Read-return stage: tag travels alongside the buffer read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1   <= 1'b0;
            tag1 <= '0;
        end else begin
            v1   <= issue;
            tag1 <= {left == ROWS_W'(1), mode_q, dst_ptr};
        end
    end

    // Busy spans acceptance to the last accumulator write; done marks it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= last2;
            if (accept)     busy <= 1'b1;
            else if (last2) busy <= 1'b0;
        end
    end

    wsmu_weight_bank #(.N(N)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_req   (wload_req),
        .wfifo_empty(wfifo_empty),
        .wfifo_row  (wfifo_row),
        .wfifo_pop  (wfifo_pop),
        .swap_req   (wswap_req),
        .swap_allow (!busy),
        .set_ready  (wset_ready),
        .act_w      (act_w)
    );

    wsmu_mac_pipe #(.N(N), .TAG_W(TAG_W)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (v1),
        .in_tag   (tag1),
        .in_row   (src_row),
        .weights  (act_w),
        .out_valid(v2),
        .out_tag  (tag2),
        .out_sums (sums2)
    );

    wsmu_acc_store #(.N(N), .DEPTH(ACC_DEPTH)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (v2),
        .wr_addr (tag2[DAW-1:0]),
        .wr_accum(tag2[DAW]),
        .wr_sums (sums2),
        .rd_addr (acc_rd_addr),
        .rd_row  (acc_rd_row)
    );
endmodule

// File: rtl/wsmu_checker.sv
// Protocol checker for wsmu_top, attached by bind. Watches ports plus the
// active weight vector; assumes synchronous active-low reset.
module wsmu_checker #(
    parameter int WBITS = 512,
    parameter int RWID  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             cmd_valid,
    input logic [RWID-1:0]  cmd_rows,
    input logic             wfifo_pop,
    input logic             wfifo_empty,
    input logic             src_rd,
    input logic [WBITS-1:0] act_w
);
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) wfifo_pop |-> !wfifo_empty); // R3
    AST_WEIGHTS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(act_w)); // R4
    AST_START_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(cmd_valid && (cmd_rows != '0))); // R5
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_READ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) src_rd |-> busy); // R8
endmodule

bind wsmu_top wsmu_checker #(
    .WBITS(N * N * wsmu_pkg::DATA_W),
    .RWID (ROWS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .cmd_valid  (cmd_valid),
    .cmd_rows   (cmd_rows),
    .wfifo_pop  (wfifo_pop),
    .wfifo_empty(wfifo_empty),
    .src_rd     (src_rd),
    .act_w      (act_w)
);

// File: tb/tb_wsmu_top.sv
// Directed bench for wsmu_top: models the weight FIFO and source buffer,
// keeps an integer reference of weights and accumulators, and compares.
module tb_wsmu_top;
    import wsmu_pkg::*;

    localparam int N = 8, SRC_DEPTH = 64, ACC_DEPTH = 32, ROWS_W = 5;
    localparam int SAW = $clog2(SRC_DEPTH), DAW = $clog2(ACC_DEPTH);
    localparam int RW = N * DATA_W, SW = N * ACC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfifo_empty, wfifo_pop, wload_req = 0, wswap_req = 0, wset_ready;
    logic [RW-1:0] wfifo_row;
    logic cmd_valid = 0, cmd_accum = 0, cmd_ready, busy, done, src_rd;
    logic [ROWS_W-1:0] cmd_rows = '0;
    logic [SAW-1:0] cmd_src = '0, src_addr;
    logic [DAW-1:0] cmd_dst = '0, acc_rd_addr = '0;
    logic [RW-1:0] src_row = '0;
    logic [SW-1:0] acc_rd_row;

    int n_chk = 0, n_bad = 0;

    logic [RW-1:0] fifo_mem [64];
    int unsigned f_wr = 0, f_rd = 0, pops = 0;
    logic [RW-1:0] src_mem [SRC_DEPTH];
    logic signed [7:0] sh_m [N][N];
    logic signed [7:0] act_m [N][N];
    logic [SW-1:0] acc_m [ACC_DEPTH];

    always #2 clk = ~clk;

    assign wfifo_empty = (f_wr == f_rd);
    assign wfifo_row   = fifo_mem[f_rd % 64];

    always @(posedge clk) if (rst_n && wfifo_pop) begin
        f_rd <= f_rd + 1;
        pops <= pops + 1;
    end

    always @(posedge clk) if (src_rd) src_row <= src_mem[src_addr];

    wsmu_top #(.N(N), .SRC_DEPTH(SRC_DEPTH), .ACC_DEPTH(ACC_DEPTH), .ROWS_W(ROWS_W)) dut (
        .clk(clk), .rst_n(rst_n), .wfifo_empty(wfifo_empty), .wfifo_row(wfifo_row),
        .wfifo_pop(wfifo_pop), .wload_req(wload_req), .wswap_req(wswap_req),
        .wset_ready(wset_ready), .cmd_valid(cmd_valid), .cmd_rows(cmd_rows),
        .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_accum(cmd_accum),
        .cmd_ready(cmd_ready), .busy(busy), .done(done), .src_rd(src_rd),
        .src_addr(src_addr), .src_row(src_row), .acc_rd_addr(acc_rd_addr),
        .acc_rd_row(acc_rd_row)
    );

    task automatic check(input bit ok, input string req, input logic [SW-1:0] got, input logic [SW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic gen_weights();
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) sh_m[k][j] = 8'($urandom);
        sh_m[0][0] = -8'sd128;
    endtask

    task automatic push_rows(input int lo, input int hi);
        for (int k = lo; k < hi; k++) begin
            logic [RW-1:0] r;
            for (int j = 0; j < N; j++) r[j*8 +: 8] = sh_m[k][j];
            fifo_mem[f_wr % 64] = r;
            f_wr = f_wr + 1;
        end
    endtask

    task automatic adopt_shadow();
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) act_m[k][j] = sh_m[k][j];
    endtask

    task automatic fill_src();
        for (int a = 0; a < SRC_DEPTH; a++) begin
            for (int k = 0; k < N; k++) src_mem[a][k*8 +: 8] = 8'($urandom);
        end
        src_mem[0] = {N{8'h80}};
    endtask

    task automatic model_cmd(input int b_rows, input int src, input int dst, input bit accum);
        for (int b = 0; b < b_rows; b++) begin
            int sa = (src + b) % SRC_DEPTH;
            int da = (dst + b) % ACC_DEPTH;
            for (int j = 0; j < N; j++) begin
                int s = 0;
                for (int k = 0; k < N; k++)
                    s += int'($signed(src_mem[sa][k*8 +: 8])) * int'(act_m[k][j]);
                if (accum) acc_m[da][j*32 +: 32] = acc_m[da][j*32 +: 32] + 32'(s);
                else       acc_m[da][j*32 +: 32] = 32'(s);
            end
        end
    endtask

    // R6 R7 R9: every accumulator row against the reference.
    task automatic compare_acc(input string req);
        for (int r = 0; r < ACC_DEPTH; r++) begin
            acc_rd_addr = DAW'(r);
            #1;
            check(acc_rd_row == acc_m[r], req, acc_rd_row, acc_m[r]);
        end
    endtask

    // One command; side 1 offers a command while busy, side 2 loads and swaps meanwhile.
    task automatic run_cmd(input int b_rows, input int src, input int dst, input bit accum,
                           input int side, input string req);
        int idx = 0, rd = 0, misplaced = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_rows = ROWS_W'(b_rows); cmd_src = SAW'(src);
        cmd_dst = DAW'(dst); cmd_accum = accum;
        model_cmd(b_rows, src, dst, accum);
        @(negedge clk);
        cmd_valid = 0;
        while (busy && idx < 200) begin
            if (side == 1 && idx == 1) begin
                check(cmd_ready == 1'b0, "R5 cmd_ready while busy", SW'(cmd_ready), '0);
                cmd_valid = 1; cmd_rows = 5'd3; cmd_dst = DAW'(dst + 16); cmd_accum = 0;
            end
            if (side == 1 && idx == 2) cmd_valid = 0;
            if (side == 2 && idx == 0) wload_req = 1;
            if (side == 2 && idx == 1) begin wload_req = 0; wswap_req = 1; end
            if (side == 2 && idx == 2) wswap_req = 0;
            if (side == 2 && idx == 3) wload_req = 1;
            if (side == 2 && idx == 4) wload_req = 0;
            if (side == 2 && idx == b_rows + 1)
                check(wset_ready == 1'b1, "R4 no swap while busy", SW'(wset_ready), SW'(1));
            if (src_rd) begin
                if (idx < b_rows) rd++; else misplaced++;
            end else if (idx < b_rows) misplaced++;
            idx++;
            @(negedge clk);
        end
        check(idx == b_rows + 2, {"R8 busy length ", req}, SW'(idx), SW'(b_rows + 2));
        check(rd == b_rows && misplaced == 0, "R8 src_rd window", SW'(rd), SW'(b_rows));
        check(done == 1'b1, "R8 done at end", SW'(done), SW'(1));
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", SW'(done), '0);
        compare_acc(req);
    endtask

    task automatic t_reset();
        for (int r = 0; r < ACC_DEPTH; r++) acc_m[r] = '0;
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) act_m[k][j] = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check({busy, done, wfifo_pop, wset_ready, cmd_ready} == 5'b00001, "R1 reset outputs",
              SW'({busy, done, wfifo_pop, wset_ready, cmd_ready}), SW'(5'b00001));
        compare_acc("R1 accumulators zero");
        fill_src();
        run_cmd(3, 5, 2, 0, 0, "R1 zero weights");
    endtask

    task automatic t_full_load();
        int p0;
        gen_weights();
        @(negedge clk);
        push_rows(0, N);
        p0 = pops;
        wload_req = 1;
        @(negedge clk);
        wload_req = 0;
        for (int i = 0; i < 40 && !wset_ready; i++) @(negedge clk);
        check(wset_ready == 1'b1 && pops - p0 == N, "R2 full load", SW'(pops - p0), SW'(N));
        wswap_req = 1;
        @(negedge clk);
        wswap_req = 0;
        @(negedge clk);
        check(wset_ready == 1'b0, "R4 swap clears ready", SW'(wset_ready), '0);
        adopt_shadow();
    endtask

    task automatic t_stalled_load();
        int p0;
        gen_weights();
        @(negedge clk);
        push_rows(0, 3);
        p0 = pops;
        wload_req = 1;
        @(negedge clk);
        wload_req = 0;
        repeat (10) @(negedge clk);
        check(pops - p0 == 3 && wset_ready == 1'b0, "R3 stall on empty", SW'(pops - p0), SW'(3));
        wswap_req = 1;
        @(negedge clk);
        wswap_req = 0;
        repeat (3) @(negedge clk);
        run_cmd(4, 9, 12, 0, 0, "R3 partial set not active");
        push_rows(3, N);
        for (int i = 0; i < 40 && (pops - p0) < N; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(pops - p0 == N && wset_ready == 1'b0, "R4 pending swap applied",
              SW'(pops - p0), SW'(N));
        adopt_shadow();
        run_cmd(4, 9, 12, 0, 0, "R3 resumed set active");
    endtask

    task automatic t_refused();
        @(negedge clk);
        cmd_valid = 1; cmd_rows = '0; cmd_dst = 5'd20;
        @(negedge clk);
        cmd_valid = 0;
        check(busy == 1'b0 && src_rd == 1'b0, "R5 zero rows refused", SW'(busy), '0);
        run_cmd(6, 40, 0, 1, 1, "R5 command while busy refused");
    endtask

    task automatic t_overlap();
        int p0;
        gen_weights();
        @(negedge clk);
        push_rows(0, N);
        p0 = pops;
        run_cmd(14, 20, 8, 0, 2, "R10 load during compute");
        check(pops - p0 == N, "R10 second request ignored", SW'(pops - p0), SW'(N));
        check(wset_ready == 1'b0, "R4 swap after idle", SW'(wset_ready), '0);
        adopt_shadow();
        run_cmd(5, 33, 9, 1, 0, "R4 new weights used");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog: got timeout exp completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_full_load();
        run_cmd(1, 7, 4, 0, 0, "R6 single row");
        run_cmd(7, 11, 4, 0, 0, "R7 overwrite");
        run_cmd(7, 18, 4, 1, 0, "R7 accumulate");
        run_cmd(6, 0, 29, 0, 0, "R6 dst wrap");
        run_cmd(8, 60, 14, 1, 0, "R6 src wrap");
        run_cmd(31, 2, 1, 1, 0, "R6 longest run");
        for (int t = 0; t < 4; t++)
            run_cmd(1 + int'($urandom % 20), int'($urandom % SRC_DEPTH),
                    int'($urandom % ACC_DEPTH), 1'($urandom), 0, "R6 random");
        t_refused();
        t_stalled_load();
        t_overlap();
        summary();
        $finish;
    end
endmodule